// File: doc/BRIEF.md
# Twister State Seeding Engine

This block fills the state memory of a twisted-feedback pseudorandom generator from a single seed word before the generator is allowed to run. A one-cycle start request latches either the seed presented on the input or a built-in default constant. The block then produces the whole state table through a serial recurrence and streams it into the shared state RAM through a plain write port, one word per write.

Word 0 is the seed itself. Every later word is formed from the word just before it. The previous word is folded with a copy of itself shifted right by two bits less than the word width. That result is multiplied by a fixed constant, and the word's own index is added, all modulo the word width. Because each word depends on the finished previous word, the work is strictly serial.

The multiply can be done in one step or split over two register stages. In the split form a word is written every second cycle. When the last word has been written, the engine drops busy and gives a one-cycle done pulse. The generator core uses that pulse to start drawing from index 0.

Top module: `twister_seed_init`

## Requirements
- R1: After reset, busy, done and wr_en are all low.
- R2: A start pulse sampled while idle makes busy high from the next cycle. The first write in that cycle goes to address 0 with data equal to seed_in, or to the default constant when use_default is 1.
- R3: The word written at address k (k from 1 to DEPTH-1) equals (MULT * (p ^ (p >> (WORD_W-2))) + k) mod 2^WORD_W, where p is the word written at address k-1 and MULT is 1812433253 by default.
- R4: With use_default = 1 at start, word 0 is DEFAULT_SEED, which is 4357 by default, whatever the value of seed_in.
- R5: Write addresses run 0, 1, 2, ... DEPTH-1, each exactly once per seeding run.
- R6: wr_en is high only while busy is high. Busy stays high until the write to address DEPTH-1.
- R7: done is a single-cycle pulse in the cycle right after the write to address DEPTH-1, with busy low. It fires once per run.
- R8: A start pulse that arrives while busy is ignored: the sequence being written and its seed do not change.
- R9: With MUL_STAGES = 1, wr_en is high on every busy cycle. With MUL_STAGES = 2, busy cycles alternate between a write and a non-write, starting with a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled only while idle |
| use_default | input | 1 | Selects DEFAULT_SEED instead of seed_in at start |
| seed_in | input | WORD_W | Seed value |
| wr_en | output | 1 | State RAM write enable |
| wr_addr | output | ADDR_W | State RAM write address |
| wr_data | output | WORD_W | State RAM write data |
| busy | output | 1 | Seeding in progress |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The bench builds two copies side by side with the default 32-bit width and the full 624-word depth: one with a single multiply stage and one with two stages. Every write of both copies is checked against a running behavioural model of the recurrence. The full depth brings the final-address boundary and the done timing within reach. The two-stage copy shows that the alternating write pattern still chains each word from the finished word before it. Runs use an explicit seed, the default seed, seeds of zero and all ones, and a start request issued in the middle of a run.

// File: rtl/twister_seed_init.sv
module twister_seed_init #(
  parameter int WORD_W = 32,
  parameter int DEPTH = 624,
  parameter int MUL_STAGES = 1,
  parameter logic [WORD_W-1:0] MULT = 32'd1812433253,
  parameter logic [WORD_W-1:0] DEFAULT_SEED = 32'd4357,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_default,
  input  logic [WORD_W-1:0] seed_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  localparam int SHIFT = WORD_W - 2;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              busy_r, done_r, phase;
  logic [ADDR_W-1:0] idx;
  logic [WORD_W-1:0] cur, mix, prod, nxt;

  assign mix = cur ^ (cur >> SHIFT);

  generate
    if (MUL_STAGES == 1) begin : g_comb_mul
      assign prod = mix * MULT;
    end else begin : g_pipe_mul
      logic [WORD_W-1:0] prod_r;
      always_ff @(posedge clk) prod_r <= mix * MULT;
      assign prod = prod_r;
    end
  endgenerate

  assign nxt     = prod + WORD_W'(idx) + WORD_W'(1);
  assign wr_en   = busy_r & ~phase;
  assign wr_addr = idx;
  assign wr_data = cur;
  assign busy    = busy_r;
  assign done    = done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
      phase  <= 1'b0;
      idx    <= '0;
      cur    <= '0;
    end else begin
      done_r <= 1'b0;
      if (!busy_r) begin
        if (start) begin
          busy_r <= 1'b1;
          phase  <= 1'b0;
          idx    <= '0;
          cur    <= use_default ? DEFAULT_SEED : seed_in;
        end
      end else if (!phase) begin
        if (idx == LAST) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end else if (MUL_STAGES == 1) begin
          cur <= nxt;
          idx <= idx + ADDR_W'(1);
        end else begin
          phase <= 1'b1;
        end
      end else begin
        cur   <= nxt;
        idx   <= idx + ADDR_W'(1);
        phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twister_seed_init_chk.sv
module twister_seed_init_chk #(
  parameter int DEPTH = 624,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              done
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  assert_wr_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_en && wr_addr == LAST)) |=> busy);

  assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && wr_en && wr_addr == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == LAST) |=> (done && !busy));

  assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en && start) |=> (busy && wr_addr != '0));
endmodule

bind twister_seed_init twister_seed_init_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
  .wr_addr(wr_addr), .busy(busy), .done(done)
);

// File: tb/twister_seed_init_tb.sv
module twister_seed_init_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 624;
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] MULT = 32'd1812433253;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, use_default = 1'b0;
  logic [31:0] seed_in = '0;
  logic [1:0] wr_en, busy, done;
  logic [AW-1:0] addr [2];
  logic [31:0] data [2];

  int compared = 0, mismatched = 0;
  int exp_idx [2];
  logic [31:0] exp_w [2];
  bit prev_wr [2];
  bit last_prev [2];
  int done_cnt [2];
  bit mon_on = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twister_seed_init #(.MUL_STAGES(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .use_default(use_default), .seed_in(seed_in),
    .wr_en(wr_en[0]), .wr_addr(addr[0]), .wr_data(data[0]), .busy(busy[0]), .done(done[0]));

  twister_seed_init #(.MUL_STAGES(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .start(start), .use_default(use_default), .seed_in(seed_in),
    .wr_en(wr_en[1]), .wr_addr(addr[1]), .wr_data(data[1]), .busy(busy[1]), .done(done[1]));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      for (int d = 0; d < 2; d++) begin
        if (busy[d])
          chk(wr_en[d] == ((d == 0) ? 1'b1 : !prev_wr[d]), "R9 write cadence", 32'(wr_en[d]), 32'(d == 0 ? 1 : !prev_wr[d]));
        else
          chk(!wr_en[d], "R6 write outside busy", 32'(wr_en[d]), 0);
        if (wr_en[d]) begin
          chk(32'(addr[d]) == 32'(exp_idx[d]), "R5 write address", 32'(addr[d]), 32'(exp_idx[d]));
          chk(data[d] == exp_w[d], exp_idx[d] == 0 ? "R2 seed word" : "R3 recurrence word", data[d], exp_w[d]);
          exp_w[d] = (exp_w[d] ^ (exp_w[d] >> 30)) * MULT + 32'(exp_idx[d] + 1);
          exp_idx[d]++;
        end
        if (done[d]) begin
          chk(last_prev[d] && !busy[d] && exp_idx[d] == DEPTH, "R7 done timing", 32'(exp_idx[d]), DEPTH);
          done_cnt[d]++;
        end
        prev_wr[d] = wr_en[d];
        last_prev[d] = wr_en[d] && 32'(addr[d]) == DEPTH - 1;
      end
    end
  end

  task automatic run(input logic [31:0] s, input bit dflt, input bit poke);
    int before0, before1;
    before0 = done_cnt[0];
    before1 = done_cnt[1];
    @(negedge clk);
    seed_in = s;
    use_default = dflt;
    start = 1'b1;
    for (int d = 0; d < 2; d++) begin
      exp_w[d] = dflt ? 32'd4357 : s;
      exp_idx[d] = 0;
    end
    @(negedge clk);
    #1;
    chk(busy == 2'b11 && wr_en == 2'b11, "R2 busy and first write", 32'({busy, wr_en}), 32'hF);
    start = 1'b0;
    seed_in = ~s;
    if (poke) begin
      repeat (41) @(negedge clk);
      seed_in = 32'hDEAD_BEEF;
      use_default = !dflt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(busy == 2'b11, "R8 restart ignored keeps busy", 32'(busy), 3);
    end
    repeat (2 * DEPTH + 10) @(negedge clk);
    #1;
    for (int d = 0; d < 2; d++) begin
      chk(exp_idx[d] == DEPTH, "R5 word count", 32'(exp_idx[d]), DEPTH);
      chk(done_cnt[d] == (d == 0 ? before0 : before1) + 1, "R7 one done per run",
          32'(done_cnt[d]), 32'((d == 0 ? before0 : before1) + 1));
      chk(!busy[d] && !done[d], "R6 idle after run", 32'({busy[d], done[d]}), 0);
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      exp_idx[d] = 0; exp_w[d] = '0; prev_wr[d] = 0; last_prev[d] = 0; done_cnt[d] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 2'b00 && done == 2'b00 && wr_en == 2'b00, "R1 reset state", 32'({busy, done, wr_en}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);
    run(32'h1234_5678, 1'b0, 1'b0);
    run(32'hCAFE_0001, 1'b1, 1'b0);  // R4 default seed overrides seed_in
    run(32'h0000_1111, 1'b0, 1'b1);  // R8 restart in the middle of a run
    run(32'h0000_0000, 1'b0, 1'b0);  // R3 zero seed
    run(32'hFFFF_FFFF, 1'b0, 1'b0);  // R3 all-ones seed
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule